// File: doc/BRIEF.md
# Serial Transmitter with Line Control

This block turns bytes into an asynchronous serial bit stream. Software writes a line control byte, the baud divisor and data bytes through a small register write port. Each byte is wrapped in a frame with these parts, in order: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. The parity bit can be odd, even, a constant 1 (mark) or a constant 0 (space). A flag tells the writer when the single holding register can take the next byte.

Bit timing comes from a baud tick input. A divisor counts baud ticks to make oversample ticks, and each bit lasts `OS_RATE` oversample ticks. A divisor of zero stops time: the line holds the bit it is on.

A break control drives the line low for as long as it is set. When it is released in the middle of a frame, the line stays low until the next bit boundary. A select bit in the line control byte redirects writes at the two lower addresses to the divisor bytes instead of the data path.

Top module: `uart_lc_tx`

## Requirements
- R1: After reset, tx is 1 and thr_empty is 1. The line control byte is 0 and the divisor is `DIV_RESET` (default 1).
- R2: Address 3 writes the line control byte. Address 0 writes the holding register when control bit 7 is 0. When control bit 7 is 1, addresses 0 and 1 write the divisor low and high bytes, and the holding register is not touched. A write to address 1 while bit 7 is 0, or any write to address 2, has no effect.
- R3: Control bits [1:0] set the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Data bits are sent least significant first, starting with bit 0 of the written byte.
- R4: A frame is one start bit of 0, then the data bits, the parity bit if enabled, and then stop bits of 1. There is one stop bit when control bit 2 is 0 and two when it is 1. An idle line is 1.
- R5: When control bit 3 is 0, no parity bit is sent, whatever bits 4 and 5 hold.
- R6: When control bit 3 is 1 and bit 5 is 0, the parity bit makes the count of ones in data plus parity odd if bit 4 is 0, and even if bit 4 is 1.
- R7: When control bits 3 and 5 are both 1, the parity bit is forced. It is 1 when bit 4 is 0, and 0 when bit 4 is 1.
- R8: With baud_tick high every cycle, each bit lasts 16 × divisor clock cycles. When a frame of N bits is followed by a byte already waiting, the two start bits begin N × 16 × divisor + 1 cycles apart.
- R9: When the divisor is 0, tx holds its current bit indefinitely.
- R10: thr_empty goes to 0 in the cycle after a data write. It returns to 1 when the byte moves to the shifter. With an idle shifter, this is one cycle later, and the start bit begins in that same cycle.
- R11: While control bit 6 is 1, tx is 0, starting in the cycle after the write that sets it.
- R12: After control bit 6 is cleared in the middle of a frame, tx stays 0 until the next bit boundary and then shows the current frame bit. When the shifter is idle, tx is 1 by the second cycle after the clearing write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| baud_tick | input | 1 | Baud time base enable |
| thr_empty | output | 1 | Holding register can accept a byte |
| tx | output | 1 | Serial output |

## Verification
The bench uses the default parameters: 16 oversample ticks per bit, a 16-bit divisor and a reset divisor of 1. With these, a bit is 16 cycles long, so all 64 framing codes (word length, stop count and the five parity modes) can be swept, each with back-to-back byte pairs, and every frame bit can be sampled at its centre. A divisor of 2, reached through the latch select, confirms that the divisor scales the bit length. A divisor of 0 shows the halt. The short bit time also keeps a break set and cleared mid-bit within a few dozen cycles of the next boundary.

// File: rtl/uart_lc_pkg.sv
package uart_lc_pkg;

   localparam int ADDR_W  = 2;
   localparam int FRAME_W = 12;   // start + 8 data + parity + 2 stop
   localparam int LEN_W   = 4;

   localparam logic [ADDR_W-1:0] A_DATA = 2'd0;
   localparam logic [ADDR_W-1:0] A_AUX  = 2'd1;
   localparam logic [ADDR_W-1:0] A_LINE = 2'd3;

   // Field order is fixed by the register encoding.
   typedef struct packed {
      logic       dlab;      // [7] divisor latch select
      logic       brk;       // [6] break
      logic       stick;     // [5] forced parity
      logic       even;      // [4] even / space select
      logic       par_en;    // [3] parity enable
      logic       two_stop;  // [2] two stop bits
      logic [1:0] wlen;      // [1:0] word length - 5
   } lcr_t;

   function automatic logic [LEN_W-1:0] frame_len(lcr_t c);
      return LEN_W'(7) + LEN_W'(c.wlen) + LEN_W'(c.par_en) + LEN_W'(c.two_stop);
   endfunction

   function automatic logic [FRAME_W-1:0] build_frame(lcr_t c, logic [7:0] d);
      logic [FRAME_W-1:0] f;
      logic [7:0]         m;
      logic               p;
      int                 n;
      n = 5 + int'(c.wlen);
      m = 8'hFF >> (2'd3 - c.wlen);
      p = c.stick ? ~c.even : (c.even ? ^(d & m) : ~^(d & m));
      f = '1;
      f[0] = 1'b0;
      for (int i = 0; i < 8; i++)
         if (i < n) f[i+1] = d[i];
      if (c.par_en) f[n+1] = p;
      return f;
   endfunction

endpackage

// File: rtl/uart_lc_regs.sv
module uart_lc_regs
   import uart_lc_pkg::*;
#(
   parameter int          DIV_W     = 16,
   parameter int unsigned DIV_RESET = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [7:0]        wr_data,
   input  logic              load,
   output lcr_t              lcr,
   output logic [DIV_W-1:0]  divisor,
   output logic [7:0]        thr,
   output logic              thr_full
);

   localparam logic [DIV_W-1:0] DIV_INIT = DIV_W'(DIV_RESET);

   logic thr_wr, lo_wr, hi_wr, line_wr;
   logic [7:0] div_lo;

   assign line_wr = wr_en && (wr_addr == A_LINE);
   assign thr_wr  = wr_en && (wr_addr == A_DATA) && !lcr.dlab;
   assign lo_wr   = wr_en && (wr_addr == A_DATA) &&  lcr.dlab;
   assign hi_wr   = wr_en && (wr_addr == A_AUX)  &&  lcr.dlab;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lcr      <= '0;
         thr      <= '0;
         thr_full <= 1'b0;
         div_lo   <= DIV_INIT[7:0];
      end else begin
         if (line_wr) lcr <= lcr_t'(wr_data);
         if (lo_wr)   div_lo <= wr_data;
         if (thr_wr) begin
            thr      <= wr_data;
            thr_full <= 1'b1;
         end else if (load) begin
            thr_full <= 1'b0;
         end
      end
   end

   generate
      if (DIV_W > 8) begin : g_wide
         logic [DIV_W-9:0] div_hi;
         always_ff @(posedge clk) begin
            if (!rst_n)     div_hi <= DIV_INIT[DIV_W-1:8];
            else if (hi_wr) div_hi <= wr_data[DIV_W-9:0];
         end
         assign divisor = {div_hi, div_lo};
      end else begin : g_narrow
         assign divisor = div_lo;
      end
   endgenerate

   assert_load_empties_R10: assert property (@(posedge clk) disable iff (!rst_n)
      load && !thr_wr |=> !thr_full);

   assert_dlab_keeps_thr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      lo_wr && !load |=> $stable(thr_full) && $stable(thr));

endmodule

// File: rtl/uart_lc_baud.sv
module uart_lc_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             baud_tick,
   input  logic             restart,
   input  logic [DIV_W-1:0] divisor,
   output logic             os_tick
);

   logic [DIV_W-1:0] cnt;
   logic             wrap, halted;

   assign halted  = (divisor == '0);
   assign wrap    = !halted && (cnt >= divisor - 1'b1);
   assign os_tick = baud_tick && wrap;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (restart || halted) cnt <= '0;
      else if (baud_tick)         cnt <= wrap ? '0 : cnt + 1'b1;
   end

endmodule

// File: rtl/uart_lc_shift.sv
module uart_lc_shift
   import uart_lc_pkg::*;
#(
   parameter int OS_RATE = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       os_tick,
   input  logic       thr_full,
   input  logic [7:0] thr,
   input  lcr_t       lcr,
   output logic       load,
   output logic       tx
);

   localparam int                OS_W   = $clog2(OS_RATE);
   localparam logic [OS_W-1:0]   OS_LAST = OS_W'(OS_RATE - 1);

   logic [FRAME_W-1:0] shreg;
   logic [LEN_W-1:0]   left;
   logic [OS_W-1:0]    ocnt, ocnt_nxt;
   logic               busy, bit_end, brk_hold, line;

   generate
      if ((OS_RATE & (OS_RATE - 1)) == 0) begin : g_pow2
         assign ocnt_nxt = ocnt + 1'b1;
      end else begin : g_cmp
         assign ocnt_nxt = (ocnt == OS_LAST) ? '0 : ocnt + 1'b1;
      end
   endgenerate

   assign load    = thr_full && !busy;
   assign bit_end = busy && os_tick && (ocnt == OS_LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         shreg <= '1;
         left  <= '0;
         ocnt  <= '0;
         busy  <= 1'b0;
      end else if (load) begin
         shreg <= build_frame(lcr, thr);
         left  <= frame_len(lcr);
         ocnt  <= '0;
         busy  <= 1'b1;
      end else if (busy && os_tick) begin
         ocnt <= ocnt_nxt;
         if (bit_end) begin
            shreg <= {1'b1, shreg[FRAME_W-1:1]};
            left  <= left - 1'b1;
            if (left == LEN_W'(1)) busy <= 1'b0;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                  brk_hold <= 1'b0;
      else if (lcr.brk)            brk_hold <= 1'b1;
      else if (!busy || bit_end)   brk_hold <= 1'b0;
   end

   assign line = busy ? shreg[0] : 1'b1;
   assign tx   = (lcr.brk || brk_hold) ? 1'b0 : line;

   assert_still_without_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy && !os_tick && !load |=> $stable(shreg) && $stable(left));

   assert_start_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> busy && (shreg[0] == 1'b0));

   assert_hold_until_edge_R12: assert property (@(posedge clk) disable iff (!rst_n)
      brk_hold && busy && !bit_end |=> brk_hold);

endmodule

// File: rtl/uart_lc_tx.sv
module uart_lc_tx
   import uart_lc_pkg::*;
#(
   parameter int          OS_RATE   = 16,
   parameter int          DIV_W     = 16,
   parameter int unsigned DIV_RESET = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_en,
   input  logic [1:0] wr_addr,
   input  logic [7:0] wr_data,
   input  logic       baud_tick,
   output logic       thr_empty,
   output logic       tx
);

   generate
      if (OS_RATE < 2)             begin : g_bad_os  $error("OS_RATE must be at least 2"); end
      if (DIV_W < 8 || DIV_W > 16) begin : g_bad_div $error("DIV_W must lie in 8..16"); end
      if (DIV_RESET >= (1 << DIV_W)) begin : g_bad_rst $error("DIV_RESET too wide"); end
   endgenerate

   lcr_t             lcr;
   logic [DIV_W-1:0] divisor;
   logic [7:0]       thr;
   logic             thr_full, load, os_tick;

   uart_lc_regs #(.DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .load(load), .lcr(lcr), .divisor(divisor), .thr(thr), .thr_full(thr_full)
   );

   uart_lc_baud #(.DIV_W(DIV_W)) u_baud (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .restart(load),
      .divisor(divisor), .os_tick(os_tick)
   );

   uart_lc_shift #(.OS_RATE(OS_RATE)) u_shift (
      .clk(clk), .rst_n(rst_n), .os_tick(os_tick), .thr_full(thr_full), .thr(thr),
      .lcr(lcr), .load(load), .tx(tx)
   );

   assign thr_empty = !thr_full;

   assert_break_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && (wr_addr == A_LINE) && wr_data[6] |=> !tx);

endmodule

// File: tb/uart_lc_tx_bench.sv
module uart_lc_tx_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic       baud_tick = 1'b1;
   logic       thr_empty, tx;

   int checks = 0;
   int errors = 0;
   int pos = 0;

   always #2.5 clk = ~clk;

   uart_lc_tx u_uart_lc_tx (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .baud_tick(baud_tick), .thr_empty(thr_empty), .tx(tx)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic adv(int p);
      while (pos < p) begin
         @(negedge clk);
         pos++;
      end
   endtask

   // Expected frame computed from the line control byte.
   function automatic int exp_frame(logic [7:0] l, logic [7:0] d, output logic [11:0] bits);
      int nb, ones, n;
      logic p;
      nb = 5 + l[1:0];
      bits = '1;
      bits[0] = 1'b0;
      ones = 0;
      for (int i = 0; i < nb; i++) begin
         bits[1+i] = d[i];
         ones += d[i];
      end
      n = 1 + nb;
      if (l[3]) begin
         if (l[5]) p = !l[4];
         else if (l[4]) p = (ones % 2) == 1;
         else p = (ones % 2) == 0;
         bits[n] = p;
         n++;
      end
      n += l[2] ? 2 : 1;
      return n;
   endfunction

   function automatic string tag(logic [7:0] l, int k);
      int nb;
      nb = 5 + l[1:0];
      if (k == 0) return "R4 start";
      if (k <= nb) return "R3 data";
      if (k == nb + 1 && l[3]) return l[5] ? "R7 parity" : "R6 parity";
      return l[3] ? "R4 stop" : "R5 stop";
   endfunction

   task automatic frame_pair(logic [7:0] l, logic [7:0] d0, logic [7:0] d1, int spb);
      logic [11:0] e0, e1;
      int n, base;
      n = exp_frame(l, d0, e0);
      void'(exp_frame(l, d1, e1));
      wr(2'd3, l);
      wr(2'd0, d0);
      chk("R10 empty after write", thr_empty, 0);
      @(negedge clk);
      pos = 0;
      chk("R10 empty after move", thr_empty, 1);
      wr_en = 1'b1; wr_addr = 2'd0; wr_data = d1;
      @(negedge clk);
      pos = 1;
      wr_en = 1'b0;
      for (int k = 0; k < n; k++) begin
         adv(k * spb + spb / 2);
         chk(tag(l, k), tx, e0[k]);
      end
      adv(n * spb);
      chk("R8 gap idle", tx, 1);
      adv(n * spb + 1);
      chk("R8 next start", tx, 0);
      base = n * spb + 1;
      for (int k = 0; k < n; k++) begin
         adv(base + k * spb + spb / 2);
         chk(tag(l, k), tx, e1[k]);
      end
      adv(base + n * spb + 2);
      chk("R4 idle high", tx, 1);
      chk("R10 empty at idle", thr_empty, 1);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual %0d expected %0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 tx", tx, 1);
      chk("R1 thr_empty", thr_empty, 1);

      // R3 R4 R5 R6 R7 R8: every framing code at reset divisor 1
      for (int c = 0; c < 64; c++) begin
         logic [7:0] d0, d1;
         d0 = 8'(c * 37 + 5);
         d1 = ~d0 ^ 8'(c);
         frame_pair(8'(c), d0, d1, 16);
      end

      // R2: divisor through the latch select, other writes ignored
      wr(2'd3, 8'h80);
      wr(2'd0, 8'h02);
      wr(2'd1, 8'h00);
      @(negedge clk);
      chk("R2 latch write leaves thr", thr_empty, 1);
      chk("R2 latch write leaves tx", tx, 1);
      wr(2'd3, 8'h00);
      wr(2'd1, 8'h77);
      wr(2'd2, 8'h55);
      frame_pair(8'h1B, 8'hC3, 8'h5A, 32);
      frame_pair(8'h3F, 8'h81, 8'h7E, 32);
      frame_pair(8'h28, 8'h13, 8'h0C, 32);

      // R9: divisor 0 halts the line on the start bit
      wr(2'd3, 8'h80);
      wr(2'd0, 8'h00);
      wr(2'd1, 8'h00);
      wr(2'd3, 8'h03);
      wr(2'd0, 8'hA5);
      repeat (100) @(negedge clk);
      chk("R9 halted start", tx, 0);
      chk("R9 byte taken", thr_empty, 1);
      wr(2'd3, 8'h83);
      wr(2'd0, 8'h01);
      wr(2'd3, 8'h03);
      repeat (12 * 16 + 20) @(negedge clk);
      chk("R9 frame resumes and ends", tx, 1);

      // R11 R12: break while idle
      wr(2'd3, 8'h43);
      chk("R11 idle break", tx, 0);
      repeat (20) @(negedge clk);
      chk("R11 break held", tx, 0);
      wr(2'd3, 8'h03);
      @(negedge clk);
      chk("R12 idle release", tx, 1);

      // R11 R12: break set and released mid-frame, all-ones data
      wr(2'd0, 8'hFF);
      @(negedge clk);
      pos = 0;
      adv(2 * 16 + 4);
      chk("R3 data before break", tx, 1);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h43;
      @(negedge clk);
      pos++;
      wr_en = 1'b0;
      chk("R11 mid-frame break", tx, 0);
      adv(3 * 16 + 4);
      wr_en = 1'b1; wr_addr = 2'd3; wr_data = 8'h03;
      @(negedge clk);
      pos++;
      wr_en = 1'b0;
      chk("R12 held after release", tx, 0);
      adv(3 * 16 + 15);
      chk("R12 held to boundary", tx, 0);
      adv(4 * 16);
      chk("R12 resumes at boundary", tx, 1);
      adv(12 * 16);
      chk("R4 idle after break frame", tx, 1);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule